// File: doc/BRIEF.md
# Interrupt Pending Aggregator

This block gathers service requests from a set of mezzanine module slots, together with an access-timeout event raised by the carrier itself, and presents them to host software in a single pending register. Each slot's request line is an asynchronous level; it is brought into the clock domain through a short synchronizer chain and shown live in the pending register. The timeout source is held in a sticky bit until software writes a 1 to it.

A control register holds a global enable, per-source enables and a signalling-mode selector. In legacy mode the block emits an assert message when an enabled source becomes pending and a deassert message once none remains, and the two always alternate. In message-signalled mode it emits one pulse each time the combined enabled-pending condition rises. An interrupt-space read aimed at one slot produces a one-cycle acknowledge strobe to that slot, which starts the vector fetch; the module then releases its request line, and the pending bit drops through the synchronizer.

Top module: `irq_pending_agg`

## Requirements
- R1: After reset both registers read 0 and the slotAck, intAssertMsg, intDeassertMsg and msiMsg outputs are 0.
- R2: Bits [NUM_SLOTS-1:0] of the pending register (offset 0x02) show the slotIrq levels with a latency of exactly two rising clock edges.
- R3: Bit 8 of the pending register is set by a timeoutEvt pulse and stays set until a write to offset 0x02 with bit 8 at 1; a write with bit 8 at 0 leaves it set, and a timeout event in the same cycle as the clearing write leaves it set.
- R4: The control register at offset 0x00 holds global enable in bit 0, message-signalled mode in bit 1, timeout enable in bit 2 and slot enables in bits [4+NUM_SLOTS-1:4]; it reads back those bits as written and reads 0 elsewhere. Other offsets read 0 and writes to them change nothing.
- R5: The enable bits never mask the pending register contents.
- R6: In legacy mode (bit 1 = 0) with global enable set, exactly one intAssertMsg pulse is sent when any enabled source becomes pending and exactly one intDeassertMsg pulse once none remains; the two messages strictly alternate.
- R7: In message-signalled mode one msiMsg pulse is sent per rising edge of the enabled-pending condition, and no intAssertMsg is sent; switching into this mode with the legacy line asserted sends one intDeassertMsg.
- R8: With global enable clear, no intAssertMsg or msiMsg pulse is sent, whatever is pending.
- R9: A cycle with intSpaceRd high and intSpaceSlot = s produces slotAck with only bit s set in the following cycle, for one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| slotIrq | input | NUM_SLOTS | Asynchronous per-slot request levels |
| timeoutEvt | input | 1 | One-cycle carrier access-timeout event |
| regAddr | input | ADDR_W | Register byte offset |
| regWrEn | input | 1 | Register write strobe |
| regWrData | input | DATA_W | Register write data |
| regRdData | output | DATA_W | Read data for regAddr (combinational) |
| intSpaceRd | input | 1 | Interrupt-space read strobe |
| intSpaceSlot | input | SLOT_IDX_W | Slot addressed by the interrupt-space read |
| slotAck | output | NUM_SLOTS | One-cycle vector-fetch strobe per slot |
| intAssertMsg | output | 1 | Legacy assert message pulse |
| intDeassertMsg | output | 1 | Legacy deassert message pulse |
| msiMsg | output | 1 | Message-signalled interrupt pulse |

## Verification
The assertions take for granted that timeoutEvt is a single-cycle strobe, that intSpaceSlot is below NUM_SLOTS whenever intSpaceRd is high, and that the register interface presents one access per cycle. The stimulus changes every input only at the falling clock edge, raises timeoutEvt for exactly one cycle, and addresses only existing slots. The sweep covers every slot request pattern against every slot-enable mask, returning all requests to idle between cases so each case starts with the legacy line deasserted.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;

  // Control register field positions
  localparam int CTL_GEN_BIT  = 0;
  localparam int CTL_MSI_BIT  = 1;
  localparam int CTL_TMO_BIT  = 2;
  localparam int CTL_SLOT_LSB = 4;

  // Pending register: timeout flag position
  localparam int PEND_TMO_BIT = 8;

  // Strobes from the control unit to the datapath
  typedef struct packed {
    logic selCtrl;
    logic selPend;
    logic wrCtrl;
    logic clrTmo;
    logic ackValid;
  } ctrlStrb_t;

endpackage

// File: rtl/irq_agg_sync.sv
module irq_agg_sync #(
  parameter int WIDTH  = 4,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);

  logic [WIDTH-1:0] chain [STAGES];

  for (genvar st = 0; st < STAGES; st++) begin : g_stage
    if (st == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (!rstN) chain[st] <= '0;
        else       chain[st] <= asyncIn;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (!rstN) chain[st] <= '0;
        else       chain[st] <= chain[st-1];
      end
    end
  end

  assign syncOut = chain[STAGES-1];

endmodule

// File: rtl/irq_agg_datapath.sv
module irq_agg_datapath
  import irq_agg_pkg::*;
#(
  parameter int NUM_SLOTS   = 4,
  parameter int DATA_W      = 16,
  parameter int SYNC_STAGES = 2,
  parameter int SLOT_IDX_W  = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1,
  parameter int CTL_FLD_W   = NUM_SLOTS + 3
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [NUM_SLOTS-1:0]  slotIrq,
  input  logic                  timeoutEvt,
  input  ctrlStrb_t             strb,
  input  logic [CTL_FLD_W-1:0]  ctrlWr,
  input  logic [SLOT_IDX_W-1:0] ackSlot,
  output logic [DATA_W-1:0]     rdData,
  output logic                  anyReq,
  output logic                  msiMode,
  output logic                  globalEn,
  output logic [NUM_SLOTS-1:0]  ackStrobe
);

  logic [NUM_SLOTS-1:0] pendSlots;
  logic [NUM_SLOTS-1:0] slotEn;
  logic                 tmoEn;
  logic                 tmoPend;
  logic [DATA_W-1:0]    ctrlWord;
  logic [DATA_W-1:0]    pendWord;

  irq_agg_sync #(.WIDTH(NUM_SLOTS), .STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rstN   (rstN),
    .asyncIn(slotIrq),
    .syncOut(pendSlots)
  );

  // Control register: field layout ctrlWr = {slotEn, tmoEn, msi, gen}
  always_ff @(posedge clk) begin
    if (!rstN) begin
      globalEn <= 1'b0;
      msiMode  <= 1'b0;
      tmoEn    <= 1'b0;
      slotEn   <= '0;
    end else if (strb.wrCtrl) begin
      globalEn <= ctrlWr[0];
      msiMode  <= ctrlWr[1];
      tmoEn    <= ctrlWr[2];
      slotEn   <= ctrlWr[3 +: NUM_SLOTS];
    end
  end

  // Sticky timeout flag; a new event wins over a clearing write
  always_ff @(posedge clk) begin
    if (!rstN)             tmoPend <= 1'b0;
    else if (timeoutEvt)   tmoPend <= 1'b1;
    else if (strb.clrTmo)  tmoPend <= 1'b0;
  end

  // One-hot vector-fetch strobes
  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_ack
    always_ff @(posedge clk) begin
      if (!rstN) ackStrobe[s] <= 1'b0;
      else       ackStrobe[s] <= strb.ackValid && (ackSlot == SLOT_IDX_W'(s));
    end
  end

  always_comb begin
    ctrlWord = '0;
    ctrlWord[CTL_GEN_BIT] = globalEn;
    ctrlWord[CTL_MSI_BIT] = msiMode;
    ctrlWord[CTL_TMO_BIT] = tmoEn;
    ctrlWord[CTL_SLOT_LSB +: NUM_SLOTS] = slotEn;
    pendWord = '0;
    pendWord[NUM_SLOTS-1:0] = pendSlots;
    pendWord[PEND_TMO_BIT]  = tmoPend;
  end

  always_comb begin
    if (strb.selCtrl)      rdData = ctrlWord;
    else if (strb.selPend) rdData = pendWord;
    else                   rdData = '0;
  end

  assign anyReq = globalEn & ((|(pendSlots & slotEn)) | (tmoPend & tmoEn));

  // R3: timeout flag is set after an event and held until cleared
  a_r3_tmo_set: assert property (@(posedge clk) disable iff (!rstN)
    timeoutEvt |=> tmoPend);
  a_r3_tmo_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (tmoPend && !strb.clrTmo) |=> tmoPend);
  // R9: at most one slot acknowledged, only after an interrupt-space read
  a_r9_ack_onehot: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(ackStrobe));
  a_r9_ack_cause: assert property (@(posedge clk) disable iff (!rstN)
    !strb.ackValid |=> (ackStrobe == '0));

endmodule

// File: rtl/irq_agg_ctrl.sv
module irq_agg_ctrl
  import irq_agg_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int CTRL_OFS = 0,
  parameter int PEND_OFS = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  input  logic              wrTmoClr,
  input  logic              intSpaceRd,
  input  logic              anyReq,
  input  logic              msiMode,
  output ctrlStrb_t         strb,
  output logic              assertMsg,
  output logic              deassertMsg,
  output logic              msiMsg
);

  logic selCtrl, selPend;
  logic wantLine, msiReq;
  logic lineUp, msiPrev;
  logic lastWasAssert;

  assign selCtrl = (regAddr == ADDR_W'(CTRL_OFS));
  assign selPend = (regAddr == ADDR_W'(PEND_OFS));

  always_comb begin
    strb.selCtrl  = selCtrl;
    strb.selPend  = selPend;
    strb.wrCtrl   = regWrEn & selCtrl;
    strb.clrTmo   = regWrEn & selPend & wrTmoClr;
    strb.ackValid = intSpaceRd;
  end

  assign wantLine = anyReq & ~msiMode;
  assign msiReq   = anyReq &  msiMode;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lineUp      <= 1'b0;
      msiPrev     <= 1'b0;
      assertMsg   <= 1'b0;
      deassertMsg <= 1'b0;
      msiMsg      <= 1'b0;
    end else begin
      assertMsg   <= wantLine & ~lineUp;
      deassertMsg <= ~wantLine & lineUp;
      lineUp      <= wantLine;
      msiMsg      <= msiReq & ~msiPrev;
      msiPrev     <= msiReq;
    end
  end

  // Independent tracker of the last legacy message sent
  always_ff @(posedge clk) begin
    if (!rstN)            lastWasAssert <= 1'b0;
    else if (assertMsg)   lastWasAssert <= 1'b1;
    else if (deassertMsg) lastWasAssert <= 1'b0;
  end

  // R6: assert and deassert strictly alternate
  a_r6_alt_assert: assert property (@(posedge clk) disable iff (!rstN)
    assertMsg |-> !lastWasAssert);
  a_r6_alt_deassert: assert property (@(posedge clk) disable iff (!rstN)
    deassertMsg |-> lastWasAssert);
  // R7: message pulses are never back to back, and only in that mode
  a_r7_msi_gap: assert property (@(posedge clk) disable iff (!rstN)
    msiMsg |=> !msiMsg);
  a_r7_msi_mode: assert property (@(posedge clk) disable iff (!rstN)
    msiMsg |-> $past(msiMode));

endmodule

// File: rtl/irq_pending_agg.sv
module irq_pending_agg
  import irq_agg_pkg::*;
#(
  parameter int NUM_SLOTS   = 4,
  parameter int ADDR_W      = 8,
  parameter int DATA_W      = 16,
  parameter int SYNC_STAGES = 2,
  parameter int CTRL_OFS    = 0,
  parameter int PEND_OFS    = 2,
  parameter int SLOT_IDX_W  = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [NUM_SLOTS-1:0]  slotIrq,
  input  logic                  timeoutEvt,
  input  logic [ADDR_W-1:0]     regAddr,
  input  logic                  regWrEn,
  input  logic [DATA_W-1:0]     regWrData,
  output logic [DATA_W-1:0]     regRdData,
  input  logic                  intSpaceRd,
  input  logic [SLOT_IDX_W-1:0] intSpaceSlot,
  output logic [NUM_SLOTS-1:0]  slotAck,
  output logic                  intAssertMsg,
  output logic                  intDeassertMsg,
  output logic                  msiMsg
);

  localparam int CTL_FLD_W = NUM_SLOTS + 3;

  ctrlStrb_t            strb;
  logic                 anyReq;
  logic                 msiMode;
  logic                 globalEn;
  logic [CTL_FLD_W-1:0] ctrlWr;
  logic [DATA_W-1:0]    unusedWrBits;

  assign ctrlWr = {regWrData[CTL_SLOT_LSB +: NUM_SLOTS],
                   regWrData[CTL_TMO_BIT],
                   regWrData[CTL_MSI_BIT],
                   regWrData[CTL_GEN_BIT]};
  assign unusedWrBits = regWrData;

  irq_agg_ctrl #(.ADDR_W(ADDR_W), .CTRL_OFS(CTRL_OFS), .PEND_OFS(PEND_OFS)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .regAddr    (regAddr),
    .regWrEn    (regWrEn),
    .wrTmoClr   (regWrData[PEND_TMO_BIT]),
    .intSpaceRd (intSpaceRd),
    .anyReq     (anyReq),
    .msiMode    (msiMode),
    .strb       (strb),
    .assertMsg  (intAssertMsg),
    .deassertMsg(intDeassertMsg),
    .msiMsg     (msiMsg)
  );

  irq_agg_datapath #(
    .NUM_SLOTS  (NUM_SLOTS),
    .DATA_W     (DATA_W),
    .SYNC_STAGES(SYNC_STAGES),
    .SLOT_IDX_W (SLOT_IDX_W),
    .CTL_FLD_W  (CTL_FLD_W)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .slotIrq   (slotIrq),
    .timeoutEvt(timeoutEvt),
    .strb      (strb),
    .ctrlWr    (ctrlWr),
    .ackSlot   (intSpaceSlot),
    .rdData    (regRdData),
    .anyReq    (anyReq),
    .msiMode   (msiMode),
    .globalEn  (globalEn),
    .ackStrobe (slotAck)
  );

  // R8: nothing is signalled while the global enable was clear
  a_r8_quiet_when_off: assert property (@(posedge clk) disable iff (!rstN)
    $past(!globalEn) |-> (!intAssertMsg && !msiMsg));
  // R6: a legacy pair is never issued in the same cycle
  a_r6_no_both: assert property (@(posedge clk) disable iff (!rstN)
    !(intAssertMsg && intDeassertMsg));

endmodule

// File: tb/irq_pending_agg_bench.sv
module irq_pending_agg_bench;

  localparam int NS = 4;

  logic        clk = 1'b0;
  logic        rstN;
  logic [NS-1:0] slotIrq;
  logic        timeoutEvt;
  logic [7:0]  regAddr;
  logic        regWrEn;
  logic [15:0] regWrData;
  logic [15:0] regRdData;
  logic        intSpaceRd;
  logic [1:0]  intSpaceSlot;
  logic [NS-1:0] slotAck;
  logic        intAssertMsg, intDeassertMsg, msiMsg;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #4 clk = ~clk;

  irq_pending_agg u_irq_pending_agg (
    .clk(clk), .rstN(rstN), .slotIrq(slotIrq), .timeoutEvt(timeoutEvt),
    .regAddr(regAddr), .regWrEn(regWrEn), .regWrData(regWrData),
    .regRdData(regRdData), .intSpaceRd(intSpaceRd), .intSpaceSlot(intSpaceSlot),
    .slotAck(slotAck), .intAssertMsg(intAssertMsg),
    .intDeassertMsg(intDeassertMsg), .msiMsg(msiMsg)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic regWrite(input logic [7:0] a, input logic [15:0] d);
    @(negedge clk);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0; regWrData = '0;
  endtask

  task automatic regRead(input logic [7:0] a, output logic [15:0] d);
    regAddr = a;
    #1;
    d = regRdData;
  endtask

  task automatic countMsgs(input int n, output int a, output int d, output int m);
    a = 0; d = 0; m = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (intAssertMsg)   a++;
      if (intDeassertMsg) d++;
      if (msiMsg)         m++;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [15:0] rd;
    int na, nd, nm;
    rstN = 1'b0; slotIrq = '0; timeoutEvt = 1'b0; regAddr = '0; regWrEn = 1'b0;
    regWrData = '0; intSpaceRd = 1'b0; intSpaceSlot = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    regRead(8'h00, rd); check("R1 ctrl", rd, 0);
    regRead(8'h02, rd); check("R1 pend", rd, 0);
    check("R1 outputs", {slotAck, intAssertMsg, intDeassertMsg, msiMsg}, 0);

    // R2 two-edge latency
    @(negedge clk); slotIrq = 4'b1010;
    regRead(8'h02, rd); check("R2 lat0", rd, 0);
    @(negedge clk); regRead(8'h02, rd); check("R2 lat1", rd, 0);
    @(negedge clk); regRead(8'h02, rd); check("R2 lat2", rd, 16'h000a);
    slotIrq = '0; repeat (3) @(negedge clk);

    // R4 control layout, read-back and dead offsets
    regWrite(8'h00, 16'hffff); regRead(8'h00, rd); check("R4 readback", rd, 16'h00f7);
    regWrite(8'h04, 16'h1234); regRead(8'h04, rd); check("R4 dead read", rd, 0);
    regRead(8'h00, rd); check("R4 dead write", rd, 16'h00f7);
    regWrite(8'h00, 16'h0000);

    // R3 sticky timeout
    @(negedge clk); timeoutEvt = 1'b1; @(negedge clk); timeoutEvt = 1'b0;
    regRead(8'h02, rd); check("R3 set", rd, 16'h0100);
    regWrite(8'h02, 16'h00ff); regRead(8'h02, rd); check("R3 write0", rd, 16'h0100);
    regWrite(8'h02, 16'h0100); regRead(8'h02, rd); check("R3 clear", rd, 0);
    @(negedge clk);
    timeoutEvt = 1'b1; regAddr = 8'h02; regWrData = 16'h0100; regWrEn = 1'b1;
    @(negedge clk);
    timeoutEvt = 1'b0; regWrEn = 1'b0;
    regRead(8'h02, rd); check("R3 set wins", rd, 16'h0100);

    // R6 timeout source in legacy mode
    regWrite(8'h00, 16'h0005); countMsgs(6, na, nd, nm);
    check("R6 tmo assert", {na[7:0], nd[7:0], nm[7:0]}, 32'h010000);
    regWrite(8'h02, 16'h0100); countMsgs(6, na, nd, nm);
    check("R6 tmo deassert", {na[7:0], nd[7:0], nm[7:0]}, 32'h000100);

    // R5/R6 sweep: every request pattern against every enable mask
    for (int mask = 0; mask < 16; mask++) begin
      regWrite(8'h00, 16'((mask << 4) | 1));
      for (int pat = 0; pat < 16; pat++) begin
        int expA;
        expA = ((pat & mask) != 0) ? 1 : 0;
        @(negedge clk); slotIrq = 4'(pat);
        countMsgs(6, na, nd, nm);
        regRead(8'h02, rd);
        check("R5 pending unmasked", rd, 32'(pat));
        check("R6 assert", {na[7:0], nd[7:0], nm[7:0]}, 32'(expA << 16));
        @(negedge clk); slotIrq = '0;
        countMsgs(6, na, nd, nm);
        check("R6 deassert", {na[7:0], nd[7:0], nm[7:0]}, 32'(expA << 8));
      end
    end

    // R7 message-signalled mode
    regWrite(8'h00, 16'h00f3);
    @(negedge clk); slotIrq = 4'b0001; countMsgs(6, na, nd, nm);
    check("R7 first rise", {na[7:0], nd[7:0], nm[7:0]}, 32'h000001);
    @(negedge clk); slotIrq = 4'b0011; countMsgs(6, na, nd, nm);
    check("R7 no repeat", {na[7:0], nd[7:0], nm[7:0]}, 0);
    @(negedge clk); slotIrq = 4'b0000; countMsgs(6, na, nd, nm);
    check("R7 fall silent", {na[7:0], nd[7:0], nm[7:0]}, 0);
    @(negedge clk); slotIrq = 4'b0100; countMsgs(6, na, nd, nm);
    check("R7 second rise", {na[7:0], nd[7:0], nm[7:0]}, 32'h000001);
    regWrite(8'h00, 16'h00f1); countMsgs(6, na, nd, nm);
    check("R7 to legacy", {na[7:0], nd[7:0], nm[7:0]}, 32'h010000);
    regWrite(8'h00, 16'h00f3); countMsgs(6, na, nd, nm);
    check("R7 switch deassert", {na[7:0], nd[7:0], nm[7:0]}, 32'h000101);
    @(negedge clk); slotIrq = '0; regWrite(8'h00, 16'h0000); countMsgs(4, na, nd, nm);

    // R8 global enable clear
    regWrite(8'h00, 16'h00f4);
    @(negedge clk); slotIrq = 4'b1111; countMsgs(6, na, nd, nm);
    check("R8 legacy off", {na[7:0], nd[7:0], nm[7:0]}, 0);
    regRead(8'h02, rd); check("R8 R5 pending visible", rd, 16'h000f);
    regWrite(8'h00, 16'h00f6); countMsgs(6, na, nd, nm);
    check("R8 msi off", {na[7:0], nd[7:0], nm[7:0]}, 0);
    @(negedge clk); slotIrq = '0; regWrite(8'h00, 16'h0000);

    // R9 vector-fetch acknowledge
    for (int s = 0; s < NS; s++) begin
      @(negedge clk); intSpaceRd = 1'b1; intSpaceSlot = 2'(s);
      @(negedge clk); intSpaceRd = 1'b0;
      #1 check("R9 ack", slotAck, 32'(1 << s));
      @(negedge clk); #1 check("R9 ack clears", slotAck, 0);
    end

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule